// File: doc/BRIEF.md
# Bus Wait-State and Strobe Generator

This block derives the phase clock of a small 8-bit microprocessor bus, together with active-low read and write strobes, from a master clock running at four times the processor rate. Each processor cycle has four quarters. The phase clock is low for the first two quarters and high for the last two. In an ordinary cycle the strobe covers the high phase.

When the address decoder selects the one slow peripheral region, the block stretches the access. It holds the phase clock high, which freezes the processor and the peripheral together. The access then fills a window of eight quarters, followed by two quarters of recovery. Inside that window the strobe waits for a configurable setup time before it asserts, so both a short-setup, long-pulse split and an even split are available. The stall output marks the quarters added beyond an ordinary cycle.

A slow mode runs the whole bus from a prescaled clock. In that mode no access is ever stretched. The decision to stretch is registered at the rising edge of the phase clock, so a select that arrives late can never change an access that has already started.

Top module: `bus_strobe_gen`

## Requirements
- R1: An ordinary cycle lasts 4 quarters. The phase clock is low in quarters 0 and 1 and high in quarters 2 and 3, and the strobe is active in quarters 2 and 3 only.
- R2: A cycle in which `sel_slow` is high and `sel_other` is low, outside slow mode, lasts 10 quarters. The phase clock stays high from quarter 2 through quarter 9.
- R3: In a stretched cycle the strobe asserts at quarter S and stays active through quarter 7. S is `setup_cfg` clamped to the range 2 to 6, so values 0 and 1 give 2 and value 7 gives 6.
- R4: In a stretched cycle the strobe is inactive for exactly 2 quarters (quarters 8 and 9) before the next cycle starts with the phase clock falling.
- R5: A cycle with `sel_slow` low, or with `sel_slow` and `sel_other` both high, is never stretched and follows R1.
- R6: With `slow_mode` high, every quarter lasts `SLOW_DIV` master clocks and no cycle is stretched, whatever the selects are.
- R7: `stall` is high in quarters 4 through 9 of a stretched cycle, which is 6 quarters, and low at all other times.
- R8: `rw` high selects a read, so only `rd_n` goes low. `rw` low selects a write, so only `wr_n` goes low. `rw` is sampled at the start of quarter 2.
- R9: `rd_n` and `wr_n` are never low at the same time.
- R10: While `rst` is high, `rd_n` and `wr_n` are high and `phi2` and `stall` are low.
- R11: The selects are sampled once per cycle, at the master edge that starts quarter 2. A change to a select after that edge does not affect the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 4x the processor rate |
| rst | input | 1 | Synchronous reset, active high |
| slow_mode | input | 1 | Run the bus from the prescaled clock, with no stretching |
| sel_slow | input | 1 | Decode select for the slow peripheral region |
| sel_other | input | 1 | Decode select for any other region |
| rw | input | 1 | High for read, low for write |
| setup_cfg | input | CFG_W | Strobe setup length in quarters for stretched cycles |
| phi2 | output | 1 | Processor phase clock |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| stall | output | 1 | High while wait and recovery quarters are being added |

## Verification
The hardest case to reach from the ports is a select that changes after the sampling edge. Two variants are needed: one where the slow select rises just after the phase clock has gone high, and one where it falls just after a stretch has been committed. The driver places these changes half a master clock after the quarter-2 edge. The monitor then checks that the cycle length and strobe timing match the values latched at that edge. Setup values below and above the clamp range are also applied back to back with ordinary cycles, so that recovery and the return to 4-quarter cycles are measured at each transition.

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int SLOW_DIV = 20,
  parameter int CFG_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_mode,
  input  logic             sel_slow,
  input  logic             sel_other,
  input  logic             rw,
  input  logic [CFG_W-1:0] setup_cfg,
  output logic             phi2,
  output logic             rd_n,
  output logic             wr_n,
  output logic             stall
);
  localparam int PW        = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int Q_HIGH    = 2;
  localparam int Q_NLAST   = 3;
  localparam int Q_WIN     = 8;
  localparam int Q_SLAST   = Q_WIN + 1;
  localparam int Q_STALL   = Q_NLAST + 1;
  localparam int SET_MIN   = 2;
  localparam int SET_MAX   = 6;

  logic [PW-1:0] pre;
  logic [3:0]    q;
  logic          stretch, rw_q;
  logic [3:0]    set_q, set_clamped;
  logic          tick, last, strobe;

  assign tick = !slow_mode || (int'(pre) == SLOW_DIV - 1);
  assign last = stretch ? (q == 4'(Q_SLAST)) : (q == 4'(Q_NLAST));

  always_comb begin
    if (int'(setup_cfg) < SET_MIN)      set_clamped = 4'(SET_MIN);
    else if (int'(setup_cfg) > SET_MAX) set_clamped = 4'(SET_MAX);
    else                                set_clamped = 4'(setup_cfg);
  end

  always_ff @(posedge clk) begin
    if (rst || !slow_mode || tick) pre <= '0;
    else                           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      stretch <= 1'b0;
      rw_q    <= 1'b1;
      set_q   <= 4'(SET_MIN);
    end else if (tick) begin
      if (last) begin
        q       <= '0;
        stretch <= 1'b0;
      end else begin
        q <= q + 1'b1;
      end
      if (q == 4'(Q_HIGH - 1)) begin
        stretch <= sel_slow && !sel_other && !slow_mode;
        rw_q    <= rw;
        set_q   <= set_clamped;
      end
    end
  end

  assign phi2   = q >= 4'(Q_HIGH);
  assign strobe = stretch ? (q >= set_q && q < 4'(Q_WIN)) : phi2;
  assign rd_n   = !(strobe && rw_q);
  assign wr_n   = !(strobe && !rw_q);
  assign stall  = stretch && q >= 4'(Q_STALL);
endmodule

module bus_strobe_gen_chk (
  input logic clk,
  input logic rst,
  input logic phi2,
  input logic rd_n,
  input logic wr_n,
  input logic stall
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
  // R1
  strobe_in_high_chk: assert property (@(posedge clk) disable iff (rst) (!rd_n || !wr_n) |-> phi2);
  // R7
  stall_in_high_chk: assert property (@(posedge clk) disable iff (rst) stall |-> phi2);
  // R4
  stall_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(stall) |-> ($fell(phi2) && rd_n && wr_n));
  // R10
  always @(posedge clk)
    if (rst) reset_idle_chk: assert (rd_n && wr_n);
endmodule

bind bus_strobe_gen bus_strobe_gen_chk i_chk (
  .clk(clk), .rst(rst), .phi2(phi2), .rd_n(rd_n), .wr_n(wr_n), .stall(stall)
);

// File: tb/test_bus_strobe_gen.sv
module test_bus_strobe_gen;
  localparam int D = 5;
  logic clk = 0, rst = 1, slow_mode = 0, sel_slow = 0, sel_other = 0, rw = 1;
  logic [2:0] setup_cfg = 3'd2;
  logic phi2, rd_n, wr_n, stall;
  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct {
    int kind; int setup; int width; int rec; int cyc; int sl_len; int sl_first;
    string tag;
  } exp_t;
  exp_t q[$];

  bus_strobe_gen #(.SLOW_DIV(D), .CFG_W(3)) i_bus_strobe_gen (
    .clk(clk), .rst(rst), .slow_mode(slow_mode), .sel_slow(sel_slow),
    .sel_other(sel_other), .rw(rw), .setup_cfg(setup_cfg),
    .phi2(phi2), .rd_n(rd_n), .wr_n(wr_n), .stall(stall));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // late: 0 none, 1 raise sel_slow after sampling edge, 2 drop it
  task automatic do_cycle(input bit sm, input bit ss, input bit so, input bit r,
                          input int cfg, input int late, input string tag);
    exp_t e;
    int s;
    @(negedge phi2);
    #1;
    slow_mode = sm; sel_slow = ss; sel_other = so; rw = r; setup_cfg = 3'(cfg);
    s = cfg < 2 ? 2 : (cfg > 6 ? 6 : cfg);
    e.kind = r ? 1 : 2; e.tag = tag;
    if (sm) begin
      e.setup = 2*D; e.width = 2*D; e.rec = 0; e.cyc = 4*D; e.sl_len = 0; e.sl_first = -1;
    end else if (ss && !so) begin
      e.setup = s; e.width = 8 - s; e.rec = 2; e.cyc = 10; e.sl_len = 6; e.sl_first = 4;
    end else begin
      e.setup = 2; e.width = 2; e.rec = 0; e.cyc = 4; e.sl_len = 0; e.sl_first = -1;
    end
    q.push_back(e);
    if (late != 0) begin
      #24;
      sel_slow = (late == 1);
    end
  endtask

  bit armed = 0, prev_phi2 = 0;
  int idx = 0, st_first = -1, st_len = 0, st_kind = 0, sl_first = -1, sl_len = 0;

  always @(negedge clk) begin
    if (rst) begin
      chk(rd_n && wr_n && !phi2 && !stall, "R10 reset state", {rd_n, wr_n, phi2, stall}, 4'b1100);
    end else begin
      if (prev_phi2 && !phi2) begin
        if (armed) begin
          exp_t e;
          if (q.size() == 0) chk(0, "queue underflow", 0, 1);
          else begin
            e = q.pop_front();
            chk(st_kind == e.kind, {e.tag, " R8 strobe kind"}, st_kind, e.kind);
            chk(st_first == e.setup, {e.tag, " setup R3"}, st_first, e.setup);
            chk(st_len == e.width, {e.tag, " width R1"}, st_len, e.width);
            chk(idx - st_first - st_len == e.rec, {e.tag, " recovery R4"}, idx - st_first - st_len, e.rec);
            chk(idx == e.cyc, {e.tag, " cycle length R2"}, idx, e.cyc);
            chk(sl_len == e.sl_len && sl_first == e.sl_first, {e.tag, " stall R7"}, sl_len, e.sl_len);
          end
        end
        armed = 1;
        idx = 0; st_first = -1; st_len = 0; st_kind = 0; sl_first = -1; sl_len = 0;
      end
      if (!rd_n && !wr_n) chk(0, "R9 both strobes low", 0, 1);
      if (!rd_n || !wr_n) begin
        if (st_first < 0) begin st_first = idx; st_kind = !rd_n ? 1 : 2; end
        st_len++;
      end
      if (stall) begin
        if (sl_first < 0) sl_first = idx;
        sl_len++;
      end
      idx++;
      prev_phi2 = phi2;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    do_cycle(0, 0, 1, 1, 2, 0, "R1 normal read");
    do_cycle(0, 0, 1, 0, 2, 0, "R1 R8 normal write");
    do_cycle(0, 1, 0, 1, 2, 0, "R2 stretch read 25/75");
    do_cycle(0, 1, 0, 0, 4, 0, "R3 stretch write 50/50");
    do_cycle(0, 0, 0, 1, 4, 0, "R5 back to normal");
    do_cycle(0, 1, 0, 1, 0, 0, "R3 clamp low");
    do_cycle(0, 1, 0, 0, 7, 0, "R3 clamp high");
    do_cycle(0, 1, 0, 1, 3, 0, "R3 setup 3");
    do_cycle(0, 1, 1, 1, 4, 0, "R5 overlap selects");
    do_cycle(0, 0, 0, 1, 4, 1, "R11 late rise");
    do_cycle(0, 1, 0, 0, 5, 2, "R11 late fall");
    do_cycle(1, 1, 0, 1, 4, 0, "R6 slow mode read");
    do_cycle(1, 1, 0, 0, 4, 0, "R6 slow mode write");
    do_cycle(0, 1, 0, 1, 6, 0, "R4 after slow mode");
    do_cycle(0, 0, 1, 0, 2, 0, "R1 final");
    @(negedge phi2);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R2 all cycles seen", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule